// File: doc/BRIEF.md
# Barrel Interleaved Thread Issuer

This block picks the thread that issues in each cycle of a fine-grained multithreaded core. Threads take turns one cycle at a time. The selector moves upward through the thread IDs from the thread that issued last, wraps past the highest ID and skips any thread whose active bit is low. When at least two threads are active, two instructions from the same thread never sit next to each other in the pipeline, so a dependent instruction always has at least one foreign slot between it and its producer.

The block also keeps a program counter for every thread. A counter moves forward by a fixed step only in the cycle its thread issues. The issued thread ID and its valid bit then enter a tag pipeline of fixed depth, and every stage shows on the ports which thread owns the instruction it holds. A flag goes high whenever two neighbouring valid stages carry the same thread.

A small state machine sorts each cycle by how many threads are active. ST_IDLE means none is active, and a bubble is injected. ST_SOLO means exactly one is active, and that thread issues every cycle. ST_ROTATE means two or more are active, and issue rotates among them. The next state is found from the active count alone: a count of 0 goes to ST_IDLE, a count of 1 goes to ST_SOLO, and a count of 2 or more goes to ST_ROTATE. Any state can move to any other state. The registered state records the mode of the instruction that now sits in stage 0.

Top module: `barrel_issuer`

## Requirements
- R1: While reset is held, every stage valid bit is 0, thread t's program counter equals BOOT_PC + t*BOOT_STRIDE, and the first issue after reset goes to the lowest-numbered active thread.
- R2: issue_valid_o is 1 exactly when at least one bit of thread_active_i is 1, and an issued ID always names a thread whose active bit is 1.
- R3: The issued thread is the first active ID found when counting upward from the previously issued ID plus one, modulo the thread count, skipping inactive threads.
- R4: With no thread active, stage 0 receives a bubble (valid 0) on the next edge and the rotation position is left unchanged.
- R5: Stage 0 takes the issue valid and ID one cycle after they are presented, and each stage k>0 takes the valid and ID of stage k-1 one cycle later.
- R6: pc_adv_o is one-hot on the issuing thread and all zero with no issue. Only that thread's counter changes, increasing by PC_STEP (modulo 2^PC_W) at the next edge.
- R7: issue_pc_o equals the current counter value of the thread being issued.
- R8: same_thread_adj_o is 1 exactly when some pair of neighbouring stages k and k+1 are both valid and hold the same ID.
- R9: With two or more threads active, the issued ID differs from the ID of the valid instruction in stage 0.
- R10: The mode register is ST_IDLE only when stage 0 is a bubble. In ST_ROTATE, valid stages 0 and 1 never hold the same ID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| thread_active_i | input | NT | Per-thread active mask, bit t for thread t |
| issue_valid_o | output | 1 | An instruction issues this cycle |
| issue_tid_o | output | TID_W | Thread selected this cycle |
| issue_pc_o | output | PC_W | Program counter of the selected thread |
| pc_adv_o | output | NT | One-hot advance strobe of the issuing thread |
| thread_pc_o | output | NT*PC_W | All program counters, thread t at bits [t*PC_W +: PC_W] |
| stage_valid_o | output | NS | Valid bit of each tag stage, stage k at bit k |
| stage_tid_o | output | NS*TID_W | Thread ID of each stage, stage k at bits [k*TID_W +: TID_W] |
| same_thread_adj_o | output | 1 | Neighbouring valid stages share a thread ID |

## Verification
A corrupted rotation pointer shows in the same cycle as a wrong issue_tid_o or a wrong issue_pc_o. A counter that takes a wrong step shows one edge later in thread_pc_o. A tag stage that fails to shift shows on stage_valid_o or stage_tid_o within at most NS edges. A wrong ID also shows as a wrong same_thread_adj_o as soon as it reaches a neighbouring valid stage. The bench compares every one of these ports with a behavioural model in every cycle, so a fault is seen within one cycle of reaching a port.

// File: rtl/barrel_pkg.sv
package barrel_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SOLO   = 2'd1,
        ST_ROTATE = 2'd2
    } issue_mode_e;

endpackage

// File: rtl/barrel_rr_pick.sv
module barrel_rr_pick #(
    parameter int NT    = 4,
    parameter int TID_W = (NT > 1) ? $clog2(NT) : 1
) (
    input  logic [NT-1:0]    active_i,
    input  logic [TID_W-1:0] last_i,
    output logic             found_o,
    output logic [TID_W-1:0] pick_o
);
    // Walk offsets from the largest down to 1 so the smallest offset wins.
    always_comb begin
        found_o = 1'b0;
        pick_o  = '0;
        for (int off = NT; off >= 1; off--) begin
            int idx;
            idx = (int'(last_i) + off) % NT;
            if (active_i[idx]) begin
                found_o = 1'b1;
                pick_o  = TID_W'(idx);
            end
        end
    end
endmodule

// File: rtl/barrel_pc_bank.sv
module barrel_pc_bank #(
    parameter int          NT          = 4,
    parameter int          PC_W        = 32,
    parameter logic [31:0] PC_STEP     = 32'd4,
    parameter logic [31:0] BOOT_PC     = 32'h0000_0000,
    parameter logic [31:0] BOOT_STRIDE = 32'h0000_1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NT-1:0]    adv_i,
    output logic [NT*PC_W-1:0] pc_o
);
    localparam logic [PC_W-1:0] STEP = PC_W'(PC_STEP);

    for (genvar t = 0; t < NT; t++) begin : g_pc
        localparam logic [PC_W-1:0] BOOT_T = PC_W'(BOOT_PC + BOOT_STRIDE * t);
        logic [PC_W-1:0] pc_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        pc_q <= BOOT_T;
            else if (adv_i[t]) pc_q <= pc_q + STEP;
        end
        assign pc_o[t*PC_W +: PC_W] = pc_q;
    end
endmodule

// File: rtl/barrel_tag_pipe.sv
module barrel_tag_pipe #(
    parameter int NS    = 4,
    parameter int TID_W = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid_i,
    input  logic [TID_W-1:0]    in_tid_i,
    output logic [NS-1:0]       valid_o,
    output logic [NS*TID_W-1:0] tid_o,
    output logic                adj_o
);
    logic [NS-1:0]    vld_q;
    logic [TID_W-1:0] tid_q [NS];

    for (genvar k = 0; k < NS; k++) begin : g_stage
        logic             nxt_v;
        logic [TID_W-1:0] nxt_t;
        if (k == 0) begin : g_head
            assign nxt_v = in_valid_i;
            assign nxt_t = in_tid_i;
        end else begin : g_body
            assign nxt_v = vld_q[k-1];
            assign nxt_t = tid_q[k-1];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vld_q[k] <= 1'b0;
                tid_q[k] <= '0;
            end else begin
                vld_q[k] <= nxt_v;
                tid_q[k] <= nxt_t;
            end
        end
        assign valid_o[k]                = vld_q[k];
        assign tid_o[k*TID_W +: TID_W]   = tid_q[k];
    end

    logic [(NS>1 ? NS-1 : 1)-1:0] pair_hit;
    if (NS > 1) begin : g_adj
        for (genvar k = 0; k < NS-1; k++) begin : g_pair
            assign pair_hit[k] = vld_q[k] & vld_q[k+1] & (tid_q[k] == tid_q[k+1]);
        end
    end else begin : g_noadj
        assign pair_hit = 1'b0;
    end
    assign adj_o = |pair_hit;
endmodule

// File: rtl/barrel_issuer.sv
module barrel_issuer
    import barrel_pkg::*;
#(
    parameter int          NT          = 4,
    parameter int          NS          = 4,
    parameter int          PC_W        = 32,
    parameter logic [31:0] PC_STEP     = 32'd4,
    parameter logic [31:0] BOOT_PC     = 32'h0000_0000,
    parameter logic [31:0] BOOT_STRIDE = 32'h0000_1000,
    parameter int          TID_W       = (NT > 1) ? $clog2(NT) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NT-1:0]       thread_active_i,
    output logic                issue_valid_o,
    output logic [TID_W-1:0]    issue_tid_o,
    output logic [PC_W-1:0]     issue_pc_o,
    output logic [NT-1:0]       pc_adv_o,
    output logic [NT*PC_W-1:0]  thread_pc_o,
    output logic [NS-1:0]       stage_valid_o,
    output logic [NS*TID_W-1:0] stage_tid_o,
    output logic                same_thread_adj_o
);
    localparam logic [TID_W-1:0] LAST_TID = TID_W'(NT - 1);
    localparam int               CNT_W    = $clog2(NT + 1);

    issue_mode_e      state_q, state_d;
    logic [TID_W-1:0] last_q;
    logic [CNT_W-1:0] act_cnt;
    logic             rr_found;
    logic [TID_W-1:0] rr_pick;
    logic             fire;
    logic [TID_W-1:0] fire_tid;

    always_comb begin
        act_cnt = '0;
        for (int t = 0; t < NT; t++) act_cnt = act_cnt + CNT_W'(thread_active_i[t]);
    end

    barrel_rr_pick #(.NT(NT), .TID_W(TID_W)) u_pick (
        .active_i (thread_active_i),
        .last_i   (last_q),
        .found_o  (rr_found),
        .pick_o   (rr_pick)
    );

    // Next mode from the active count.
    always_comb begin
        if (act_cnt == '0)      state_d = ST_IDLE;
        else if (act_cnt == 1)  state_d = ST_SOLO;
        else                    state_d = ST_ROTATE;
    end

    // Mode register: the mode under which stage 0's content issued.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Issue decisions per mode.
    always_comb begin
        fire     = 1'b0;
        fire_tid = '0;
        unique case (state_d)
            ST_IDLE: begin
                fire     = 1'b0;
                fire_tid = '0;
            end
            ST_SOLO: begin
                fire     = rr_found;
                fire_tid = rr_pick;
            end
            ST_ROTATE: begin
                fire     = rr_found;
                fire_tid = rr_pick;
            end
            default: begin
                fire     = 1'b0;
                fire_tid = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    last_q <= LAST_TID;
        else if (fire) last_q <= fire_tid;
    end

    always_comb begin
        pc_adv_o = '0;
        if (fire) pc_adv_o[fire_tid] = 1'b1;
    end

    barrel_pc_bank #(
        .NT(NT), .PC_W(PC_W), .PC_STEP(PC_STEP),
        .BOOT_PC(BOOT_PC), .BOOT_STRIDE(BOOT_STRIDE)
    ) u_pcs (
        .clk   (clk),
        .rst_n (rst_n),
        .adv_i (pc_adv_o),
        .pc_o  (thread_pc_o)
    );

    barrel_tag_pipe #(.NS(NS), .TID_W(TID_W)) u_tags (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid_i (fire),
        .in_tid_i   (fire_tid),
        .valid_o    (stage_valid_o),
        .tid_o      (stage_tid_o),
        .adj_o      (same_thread_adj_o)
    );

    assign issue_valid_o = fire;
    assign issue_tid_o   = fire_tid;
    assign issue_pc_o    = thread_pc_o[fire_tid*PC_W +: PC_W];
endmodule

// File: rtl/barrel_issuer_chk.sv
module barrel_issuer_chk #(
    parameter int          NT      = 4,
    parameter int          NS      = 4,
    parameter int          PC_W    = 32,
    parameter logic [31:0] PC_STEP = 32'd4,
    parameter int          TID_W   = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NT-1:0]       thread_active_i,
    input logic                issue_valid_o,
    input logic [TID_W-1:0]    issue_tid_o,
    input logic [NT-1:0]       pc_adv_o,
    input logic [NT*PC_W-1:0]  thread_pc_o,
    input logic [NS-1:0]       stage_valid_o,
    input logic [NS*TID_W-1:0] stage_tid_o,
    input logic [1:0]          state_q
);
    localparam logic [PC_W-1:0] STEP = PC_W'(PC_STEP);

    p_valid_iff_active_r2: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid_o == (|thread_active_i));

    p_pick_is_active_r2: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid_o |-> thread_active_i[issue_tid_o]);

    p_adv_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pc_adv_o) && ((|pc_adv_o) == issue_valid_o));

    p_head_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid_o |=> stage_valid_o[0] && stage_tid_o[TID_W-1:0] == $past(issue_tid_o));

    p_bubble_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_valid_o |=> !stage_valid_o[0]);

    p_no_repeat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(thread_active_i) >= 2 && stage_valid_o[0])
            |-> issue_tid_o != stage_tid_o[TID_W-1:0]);

    p_idle_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == 2'd0 |-> !stage_valid_o[0]);

    p_rotate_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == 2'd2 && stage_valid_o[0] && stage_valid_o[1])
            |-> stage_tid_o[TID_W-1:0] != stage_tid_o[TID_W +: TID_W]);

    for (genvar k = 1; k < NS; k++) begin : g_shift
        p_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
            stage_valid_o[k-1] |=> stage_valid_o[k] &&
                stage_tid_o[k*TID_W +: TID_W] == $past(stage_tid_o[(k-1)*TID_W +: TID_W]));
    end

    for (genvar t = 0; t < NT; t++) begin : g_pc
        p_pc_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
            pc_adv_o[t] |=> thread_pc_o[t*PC_W +: PC_W] == $past(thread_pc_o[t*PC_W +: PC_W]) + STEP);
        p_pc_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
            !pc_adv_o[t] |=> $stable(thread_pc_o[t*PC_W +: PC_W]));
    end
endmodule

bind barrel_issuer barrel_issuer_chk #(
    .NT(NT), .NS(NS), .PC_W(PC_W), .PC_STEP(PC_STEP), .TID_W(TID_W)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .thread_active_i (thread_active_i),
    .issue_valid_o   (issue_valid_o),
    .issue_tid_o     (issue_tid_o),
    .pc_adv_o        (pc_adv_o),
    .thread_pc_o     (thread_pc_o),
    .stage_valid_o   (stage_valid_o),
    .stage_tid_o     (stage_tid_o),
    .state_q         (state_q)
);

// File: tb/barrel_issuer_test.sv
module barrel_issuer_test;
    localparam int CLK_PERIOD = 10;
    localparam int NT = 4, NS = 4, PC_W = 32, TID_W = 2;
    localparam logic [31:0] STEP = 32'd4, BOOT = 32'h0, STRIDE = 32'h1000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [NT-1:0] act = '0;
    logic issue_valid, adj;
    logic [TID_W-1:0] issue_tid;
    logic [PC_W-1:0] issue_pc;
    logic [NT-1:0] pc_adv;
    logic [NT*PC_W-1:0] pcs;
    logic [NS-1:0] svld;
    logic [NS*TID_W-1:0] stid;

    int n_chk = 0, n_fail = 0;

    // Behavioural model state
    int unsigned m_pc [NT];
    int m_last;
    bit m_v [$];
    int m_t [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    barrel_issuer uut (
        .clk(clk), .rst_n(rst_n), .thread_active_i(act),
        .issue_valid_o(issue_valid), .issue_tid_o(issue_tid), .issue_pc_o(issue_pc),
        .pc_adv_o(pc_adv), .thread_pc_o(pcs), .stage_valid_o(svld),
        .stage_tid_o(stid), .same_thread_adj_o(adj)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint actv, input longint expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, actv, expv);
        end
    endtask

    task automatic model_reset();
        for (int t = 0; t < NT; t++) m_pc[t] = BOOT + STRIDE * t;
        m_last = NT - 1;
        m_v.delete(); m_t.delete();
        for (int k = 0; k < NS; k++) begin m_v.push_back(1'b0); m_t.push_back(0); end
    endtask

    task automatic check_state(input string req);
        bit m_adj = 0;
        for (int k = 0; k < NS; k++) begin
            chk(svld[k] == m_v[k], "R5", "stage valid", svld[k], m_v[k]);
            if (m_v[k])
                chk(stid[k*TID_W +: TID_W] == m_t[k], "R5", "stage tid",
                    stid[k*TID_W +: TID_W], m_t[k]);
        end
        for (int k = 0; k + 1 < NS; k++)
            if (m_v[k] && m_v[k+1] && m_t[k] == m_t[k+1]) m_adj = 1;
        chk(adj == m_adj, "R8", "adjacency flag", adj, m_adj);
        for (int t = 0; t < NT; t++)
            chk(pcs[t*PC_W +: PC_W] == m_pc[t], req, "thread pc", pcs[t*PC_W +: PC_W], m_pc[t]);
    endtask

    task automatic step(input logic [NT-1:0] a);
        bit found = 0;
        int pick = 0, cnt = 0;
        logic [NT-1:0] exp_adv = '0;
        @(negedge clk);
        act = a;
        #1;
        check_state("R6");
        for (int i = 1; i <= NT; i++) begin
            int idx = (m_last + i) % NT;
            if (!found && a[idx]) begin found = 1; pick = idx; end
        end
        for (int t = 0; t < NT; t++) cnt += a[t];
        chk(issue_valid == found, found ? "R2" : "R4", "issue valid", issue_valid, found);
        if (found) begin
            exp_adv[pick] = 1'b1;
            chk(issue_tid == pick, "R3", "issue tid", issue_tid, pick);
            chk(issue_pc == m_pc[pick], "R7", "issue pc", issue_pc, m_pc[pick]);
            if (cnt >= 2 && m_v[0])
                chk(issue_tid != m_t[0], "R9", "repeat thread", issue_tid, m_t[0]);
        end
        chk(pc_adv == exp_adv, "R6", "advance strobe", pc_adv, exp_adv);
        @(posedge clk);
        void'(m_v.pop_back()); void'(m_t.pop_back());
        m_v.push_front(found); m_t.push_front(pick);
        if (found) begin m_pc[pick] += STEP; m_last = pick; end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        #1;
        check_state("R1");   // reset: stages empty, boot PCs
        rst_n = 1'b1;
        // R1: first pick after reset is lowest active
        step(4'b0110);
        // R3: full rotation
        repeat (12) step(4'b1111);
        // R3: skipping inactive, wrap
        repeat (10) step(4'b1010);
        repeat (6)  step(4'b0101);
        // R8: single thread gives adjacency
        repeat (8)  step(4'b0100);
        // R4: bubbles, pointer retained
        repeat (6)  step(4'b0000);
        repeat (4)  step(4'b1001);
        // R9: mixed random patterns
        for (int c = 0; c < 400; c++) step(4'($urandom));
        // Reset again mid-run
        @(negedge clk);
        rst_n = 1'b0; act = '0;
        model_reset();
        #1;
        check_state("R1");
        @(negedge clk);
        rst_n = 1'b1;
        repeat (8) step(4'b1110);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule